// File: doc/BRIEF.md
# Binary Tree Route Sequencer

This block works out the path a message takes between two leaves of a binary tree network and hands it out as a stream of hops. Each leaf address is an `ADDR_W`-bit word. Read from the most significant bit down, its bits steer a walk down from the root, so the tree is `ADDR_W` levels tall. The block XORs the source and destination addresses. The highest set bit of the difference gives the level of the lowest common ancestor.

A request carries a source and a destination and is taken only while the block is idle. The addresses are captured at that moment. The block then presents one hop per cycle on a valid/ready stream. All upward hops come first. The downward hops follow, and each one says whether to take the left or the right child. After the final hop has been taken, a one-cycle done pulse closes the route and the block becomes idle again.

Top module: `tree_route_unit`

## Requirements
- R1: While reset is asserted and until the first request, `req_ready` is 1 and both `hop_valid` and `done` are 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge that takes a request through the cycle in which `done` is high, and requests offered during that time have no effect.
- R3: With m the index of the highest 1 in `req_dst ^ req_src`, the route starts with exactly m+1 hops that carry `hop_down = 0` (up) and `hop_right = 0`. No up hop follows a down hop.
- R4: After the up hops come m+1 hops with `hop_down = 1`. Their `hop_right` values are destination bits m, m-1, ... 0 in that order, where 0 means left child and 1 means right child.
- R5: `hop_last` is 1 only on the final down hop of a route.
- R6: A route with differing addresses has exactly 2*(m+1) hops. This holds for every source/destination pair at `ADDR_W = 4`.
- R7: When source equals destination, no hop is presented and `done` is 1 in the cycle after the request is taken.
- R8: `done` is high for exactly one cycle, in the cycle after the final hop handshake, with `hop_valid` low. In the following cycle `req_ready` is 1.
- R9: While `hop_valid` is 1 and `hop_ready` is 0, the hop stays valid and `hop_down`, `hop_right` and `hop_last` hold their values.
- R10: The route depends only on the addresses present at the accepting edge. Later changes on `req_src` and `req_dst` do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| req_valid | input | 1 | Route request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_src | input | ADDR_W | Source leaf address |
| req_dst | input | ADDR_W | Destination leaf address |
| hop_valid | output | 1 | A hop is presented |
| hop_ready | input | 1 | Consumer takes the presented hop |
| hop_down | output | 1 | 0 = up hop, 1 = down hop |
| hop_right | output | 1 | On a down hop: 1 = right child, 0 = left child; 0 on up hops |
| hop_last | output | 1 | Final hop of the route |
| done | output | 1 | One-cycle pulse, route finished |

## Verification
The first hop appears in the cycle after the accepting edge. Each further hop appears in the cycle after the previous handshake. `done` appears one cycle after the last handshake, or one cycle after acceptance when the addresses match. The bench holds a behavioural model that advances on the same rising edge as the design. It compares every output at the following falling edge, so each expected value is sampled in exactly the cycle it becomes due. Runs with a stalling consumer and with addresses that change after acceptance check that nothing drifts by a cycle or picks up late inputs.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_UP   = 2'd1,
    RS_DOWN = 2'd2,
    RS_FIN  = 2'd3
  } route_state_e;

endpackage

// File: rtl/tr_rst_sync.sv
module tr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tr_level_calc.sv
module tr_level_calc #(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [LVL_W-1:0]  levels
);

  logic [ADDR_W-1:0] diff;
  logic [LVL_W-1:0]  cand [ADDR_W+1];

  assign diff    = addr_a ^ addr_b;
  assign cand[0] = '0;

  // Priority chain: a higher set bit overrides every lower one.
  for (genvar k = 0; k < ADDR_W; k++) begin : g_scan
    assign cand[k+1] = diff[k] ? LVL_W'(k + 1) : cand[k];
  end

  assign levels = cand[ADDR_W];

endmodule

// File: rtl/tr_step_ctrl.sv
module tr_step_ctrl
  import tree_route_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [LVL_W-1:0] start_levels,
  input  logic         hop_take,
  output route_state_e state,
  output logic [LVL_W-1:0] remain
);

  route_state_e     state_q, state_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic [LVL_W-1:0] lvl_q;
  logic             cnt_en, lvl_en;
  logic             final_step;

  assign final_step = (cnt_q == LVL_W'(1));
  assign lvl_en     = start;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      RS_IDLE: begin
        if (start) begin
          cnt_en  = 1'b1;
          cnt_d   = start_levels;
          state_d = (start_levels == '0) ? RS_FIN : RS_UP;
        end
      end
      RS_UP: begin
        if (hop_take) begin
          cnt_en = 1'b1;
          if (final_step) begin
            cnt_d   = lvl_q;
            state_d = RS_DOWN;
          end else begin
            cnt_d = cnt_q - LVL_W'(1);
          end
        end
      end
      RS_DOWN: begin
        if (hop_take) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - LVL_W'(1);
          if (final_step) begin
            state_d = RS_FIN;
          end
        end
      end
      RS_FIN: begin
        state_d = RS_IDLE;
      end
      default: begin
        state_d = RS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= start_levels;
    end
  end

  assign state  = state_q;
  assign remain = cnt_q;

endmodule

// File: rtl/tr_hop_emit.sv
module tr_hop_emit
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = 3,
  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  route_state_e      state,
  input  logic [LVL_W-1:0]  remain,
  input  logic [ADDR_W-1:0] dst_q,
  output logic              req_ready,
  output logic              hop_valid,
  output logic              hop_down,
  output logic              hop_right,
  output logic              hop_last,
  output logic              done
);

  logic [LVL_W-1:0] bit_pos;
  logic [IDX_W-1:0] sel;

  // Down hop with k levels still to go reads destination bit k-1.
  assign bit_pos = remain - LVL_W'(1);
  assign sel     = bit_pos[IDX_W-1:0];

  always_comb begin
    req_ready = 1'b0;
    hop_valid = 1'b0;
    hop_down  = 1'b0;
    hop_right = 1'b0;
    hop_last  = 1'b0;
    done      = 1'b0;
    unique case (state)
      RS_IDLE: req_ready = 1'b1;
      RS_UP:   hop_valid = 1'b1;
      RS_DOWN: begin
        hop_valid = 1'b1;
        hop_down  = 1'b1;
        hop_right = dst_q[sel];
        hop_last  = (remain == LVL_W'(1));
      end
      RS_FIN:  done = 1'b1;
      default: req_ready = 1'b0;
    endcase
  end

endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  output logic              hop_valid,
  input  logic              hop_ready,
  output logic              hop_down,
  output logic              hop_right,
  output logic              hop_last,
  output logic              done
);

  localparam int LVL_W = $clog2(ADDR_W + 1);

  logic              rst_n_int;
  logic              start;
  logic              hop_take;
  logic [LVL_W-1:0]  levels_in;
  logic [LVL_W-1:0]  remain;
  logic [ADDR_W-1:0] dst_q;
  logic              dst_en;
  route_state_e      state;

  tr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tr_level_calc #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_lvl (
    .addr_a (req_src),
    .addr_b (req_dst),
    .levels (levels_in)
  );

  assign start    = req_valid && req_ready;
  assign hop_take = hop_valid && hop_ready;
  assign dst_en   = start;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      dst_q <= '0;
    end else if (dst_en) begin
      dst_q <= req_dst;
    end
  end

  tr_step_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start        (start),
    .start_levels (levels_in),
    .hop_take     (hop_take),
    .state        (state),
    .remain       (remain)
  );

  tr_hop_emit #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_emit (
    .state     (state),
    .remain    (remain),
    .dst_q     (dst_q),
    .req_ready (req_ready),
    .hop_valid (hop_valid),
    .hop_down  (hop_down),
    .hop_right (hop_right),
    .hop_last  (hop_last),
    .done      (done)
  );

endmodule

// File: rtl/tree_route_chk.sv
module tree_route_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_src,
  input logic [ADDR_W-1:0] req_dst,
  input logic              hop_valid,
  input logic              hop_ready,
  input logic              hop_down,
  input logic              hop_right,
  input logic              hop_last,
  input logic              done
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid || done) |-> !req_ready); // R2

  AST_UP_BEFORE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && hop_ready && hop_down && !hop_last) |=> (hop_valid && hop_down)); // R3

  AST_UP_GOES_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && !hop_down) |-> !hop_right); // R3

  AST_LAST_IS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && hop_last) |-> hop_down); // R5

  AST_SAME_ADDR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_src == req_dst)) |=> (done && !hop_valid)); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && hop_ready && hop_last) |=> (done && !hop_valid)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && !hop_ready) |=> (hop_valid && $stable(hop_down)
      && $stable(hop_right) && $stable(hop_last))); // R9

endmodule

bind tree_route_unit tree_route_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tree_route_unit_test.sv
module tree_route_unit_test;

  localparam int N       = 4;
  localparam int CLK_T   = 10;
  localparam int MAX_CYC = 150000;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [N-1:0] req_src;
  logic [N-1:0] req_dst;
  logic         hop_valid;
  logic         hop_ready;
  logic         hop_down;
  logic         hop_right;
  logic         hop_last;
  logic         done;

  int n_chk;
  int n_bad;
  int cyc;

  // behavioural model
  logic [2:0] exp_q [$];   // {down, right, last}
  bit         m_busy;
  bit         m_done;
  bit         m_acc;
  int         hops_seen;
  int         lfsr;

  tree_route_unit #(.ADDR_W(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_src   (req_src),
    .req_dst   (req_dst),
    .hop_valid (hop_valid),
    .hop_ready (hop_ready),
    .hop_down  (hop_down),
    .hop_right (hop_right),
    .hop_last  (hop_last),
    .done      (done)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  function automatic int top_bit(input logic [N-1:0] x);
    int r = -1;
    for (int k = 0; k < N; k++) if (x[k]) r = k;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Model update on the edge, then output comparison on the falling edge.
  task automatic tick();
    bit dn;
    @(posedge clk);
    cyc++;
    m_acc = 1'b0;
    dn = 1'b0;
    if (exp_q.size() > 0 && hop_ready) begin
      void'(exp_q.pop_front());
      hops_seen++;
      if (exp_q.size() == 0) dn = 1'b1;
    end
    if (m_done) m_busy = 1'b0;
    else if (!m_busy && req_valid) begin
      int m;
      m_busy = 1'b1;
      m_acc  = 1'b1;
      hops_seen = 0;
      m = top_bit(req_src ^ req_dst);
      for (int k = 0; k <= m; k++) exp_q.push_back(3'b000);
      for (int k = m; k >= 0; k--) exp_q.push_back({1'b1, req_dst[k], (k == 0)});
      if (m < 0) dn = 1'b1;
    end
    m_done = dn;
    @(negedge clk);
    check(req_ready == !m_busy, "R2 req_ready", req_ready, !m_busy);
    check(hop_valid == (exp_q.size() > 0), "R6 hop_valid", hop_valid, exp_q.size() > 0);
    check(done == m_done, "R8/R7 done", done, m_done);
    if (exp_q.size() > 0 && hop_valid) begin
      check(hop_down == exp_q[0][2], "R3 hop_down", hop_down, exp_q[0][2]);
      check(hop_right == exp_q[0][1], "R4 hop_right", hop_right, exp_q[0][1]);
      check(hop_last == exp_q[0][0], "R5 hop_last", hop_last, exp_q[0][0]);
    end
  endtask

  // mode bit0: stall consumer, bit1: scramble addresses while busy
  task automatic run_pair(input logic [N-1:0] s, input logic [N-1:0] d, input int mode);
    int lim = 0;
    int m;
    m = top_bit(s ^ d);
    req_valid = 1'b1;
    req_src = s;
    req_dst = d;
    hop_ready = 1'b1;
    do begin
      tick();
      lim++;
      if (cyc > MAX_CYC) lim = 1000;
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      if (mode[0]) hop_ready = lfsr[9] | lfsr[4];
      if (mode[1] && m_busy) begin
        req_src = lfsr[N+11:12];
        req_dst = lfsr[N+19:20];
      end
    end while (!m_done && lim < 100);
    check(lim < 100, "R6 watchdog", lim, 100);
    check(hops_seen == 2 * (m + 1), "R6 hop total", hops_seen, 2 * (m + 1));
    req_valid = 1'b0;
    hop_ready = 1'b1;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; lfsr = 7;
    m_busy = 0; m_done = 0; m_acc = 0; hops_seen = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_src = '0;
    req_dst = '0;
    hop_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
    check(hop_valid == 1'b0, "R1 hop_valid in reset", hop_valid, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check(req_ready && !hop_valid && !done, "R1 idle after release", req_ready, 1);

    // R6, R3, R4, R5, R7: every pair, free-flowing consumer
    for (int s = 0; s < (1 << N); s++)
      for (int d = 0; d < (1 << N); d++)
        run_pair(N'(s), N'(d), 0);

    // R9: stalling consumer
    for (int k = 0; k < 40; k++) run_pair(N'(k * 5), N'(k * 11 + 3), 1);

    // R10 and R2: inputs change and a request is held while busy
    for (int k = 0; k < 40; k++) run_pair(N'(k * 7 + 1), N'(k * 3), 3);

    // R7: equal addresses back to back
    run_pair(N'(9), N'(9), 0);
    run_pair(N'(0), N'(0), 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule